// File: doc/BRIEF.md
# Timebase Transfer Target Selector

This block decides which core's timebase is loaded with the chip time value, and then drives the load handshake toward that core. Software first writes a target-control register. The block decodes that word in one of two ways. In full-address mode, the word carries a complete register address, and a core is chosen by comparing the upper part of that address with each core's register base. In core-ID mode, the word carries a small core number. The result of the decode is stored as a target index together with a valid flag.

Later, software writes a move command. The block accepts the move only when four things are all true: the chip time state machine reports running, the command bit is set, a valid target is stored, and the target core reports that it is ready. If the move is accepted, the block sends a one-cycle strobe to that core alone. A single strobe loads every thread of the core, so one request per core is enough. If any of the four conditions fails, no strobe is sent. Instead, a sticky error bit is set, and software can read and clear it.

Bit positions below use big-endian numbering on the 64-bit data word, so bit 0 is the MSB (`wr_data[63]`) and bit 63 is the LSB (`wr_data[0]`).

Top module: `timebase_xfer_sel`

## Requirements
- R1: After reset, no target is valid, the error bit is clear and no strobe is asserted.
- R2: A write at offset 0x27 with bit 35 set (`wr_data[28]`) selects full-address mode. The address is bits 0..31 (`wr_data[63:32]`). If its low 12 bits equal 0x4A3 and its upper 20 bits equal the base of core i (base = 0x20000000 + i*0x01000000), then from the next cycle the target is valid with index i.
- R3: In full-address mode, the target becomes invalid if the low 12 bits differ from 0x4A3, or if no core base matches.
- R4: A write at 0x27 with bit 35 clear selects core-ID mode. The core number is bits 26..31 (`wr_data[37:32]`) masked to 5 bits (`wr_data[36:32]`). A number below NCORES gives a valid target; any other number gives an invalid target. When CORE_ID_EN is 0, this mode always leaves the target invalid.
- R5: A write at 0x17 with bit 0 set (`wr_data[63]`) is accepted when tod_running is high, a target is valid and that core's ready input is high. In that case `tb_load` is exactly the one-hot bit of the target core for one cycle, starting the cycle after the write.
- R6: A write at 0x17 whose gating fails (not running, bit 0 clear, no valid target, or target not ready) produces no strobe and sets the sticky error bit from the next cycle.
- R7: `rd_data` is combinational. At rd_addr 0x27 it always reads zero. At rd_addr 0x30 it reads the error bit in bit 0 (`rd_data[63]`) and zero elsewhere.
- R8: A write at 0x30 with bit 0 set clears the error bit. Apart from that, the error bit holds its value.
- R9: Writes at other offsets change neither the target, nor the error bit, nor the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | OFS_W | Register write offset |
| wr_data | input | 64 | Write data, big-endian bit numbering |
| rd_addr | input | OFS_W | Register read offset |
| rd_data | output | 64 | Combinational read data |
| tod_running | input | 1 | Chip time state machine is running |
| core_ready | input | NCORES | Per-core timebase ready for time value |
| tb_load | output | NCORES | One-cycle sent-to-timebase strobe per core |
| tgt_valid | output | 1 | A decoded target is stored |
| tgt_core | output | $clog2(NCORES) | Stored target core index |
| xfer_err | output | 1 | Sticky rejected-move error |

## Verification
The bench goes after several corner cases, and each one exposes a specific mistake:
- **Slot offset check:** full-address words with a matching base but a wrong low-12-bit slot. A design that skipped the check would load a target.
- **Unmatched base:** addresses whose base matches no core. A design that kept the old target would strobe a stale core.
- **Core-ID masking:** core numbers with bit 5 set. A design that did not mask would reject these.
- **Out-of-range core numbers:** numbers above the core count. A design that did not range-check would accept them.
- **Move gating:** each gating condition is toggled on its own. A design that checked only some of the four would strobe when it must flag an error, or would flag when it must strobe.
- **Second instance with core-ID mode disabled:** it must leave the target invalid for core-ID writes.

// File: rtl/timebase_xfer_sel.sv
module timebase_xfer_sel #(
  parameter int                NCORES      = 8,
  parameter int                OFS_W       = 6,
  parameter logic [OFS_W-1:0]  TGT_OFS     = 6'h27,
  parameter logic [OFS_W-1:0]  MOVE_OFS    = 6'h17,
  parameter logic [OFS_W-1:0]  ERR_OFS     = 6'h30,
  parameter logic [11:0]       SLOT_REG    = 12'h4A3,
  parameter logic [31:0]       CORE_BASE0  = 32'h2000_0000,
  parameter logic [31:0]       CORE_STRIDE = 32'h0100_0000,
  parameter bit                CORE_ID_EN  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [OFS_W-1:0]          wr_addr,
  input  logic [63:0]               wr_data,
  input  logic [OFS_W-1:0]          rd_addr,
  output logic [63:0]               rd_data,
  input  logic                      tod_running,
  input  logic [NCORES-1:0]         core_ready,
  output logic [NCORES-1:0]         tb_load,
  output logic                      tgt_valid,
  output logic [$clog2(NCORES)-1:0] tgt_core,
  output logic                      xfer_err
);
  localparam int IDX_W = $clog2(NCORES);

  // Decode of the written target-control word
  logic              tgt_wr, move_wr, clr_wr;
  logic              addr_mode, slot_ok, hit_any, id_ok, dec_ok, go;
  logic [31:0]       addr_word;
  logic [4:0]        core_id;
  logic [NCORES-1:0] base_hit;
  logic [IDX_W-1:0]  hit_idx, dec_idx;
  logic              unused_bits;

  assign tgt_wr    = wr_en && (wr_addr == TGT_OFS);
  assign move_wr   = wr_en && (wr_addr == MOVE_OFS);
  assign clr_wr    = wr_en && (wr_addr == ERR_OFS);
  assign addr_mode = wr_data[28];
  assign addr_word = wr_data[63:32];
  assign slot_ok   = (addr_word[11:0] == SLOT_REG);
  assign core_id   = wr_data[36:32];
  assign unused_bits = ^{wr_data[31:29], wr_data[27:0]};

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    localparam logic [31:0] BASE = CORE_BASE0 + CORE_STRIDE * i;
    assign base_hit[i] = (addr_word[31:12] == BASE[31:12]);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = NCORES - 1; i >= 0; i--) begin
      if (base_hit[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign id_ok   = CORE_ID_EN && ({27'b0, core_id} < 32'(NCORES));
  assign dec_ok  = addr_mode ? (slot_ok && hit_any) : id_ok;
  assign dec_idx = addr_mode ? hit_idx : core_id[IDX_W-1:0];

  // Move gating: all four conditions must hold
  assign go = move_wr && tod_running && wr_data[63] && tgt_valid && core_ready[tgt_core];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_valid <= 1'b0;
      tgt_core  <= '0;
      tb_load   <= '0;
      xfer_err  <= 1'b0;
    end else begin
      if (tgt_wr) begin
        tgt_valid <= dec_ok;
        if (dec_ok) tgt_core <= dec_idx;
      end
      tb_load <= go ? (NCORES'(1) << tgt_core) : '0;
      if (move_wr && !go)          xfer_err <= 1'b1;
      else if (clr_wr && wr_data[63]) xfer_err <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ERR_OFS) rd_data[63] = xfer_err;
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tb_load)); // R5
  AST_LOAD_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (move_wr && tgt_valid && !core_ready[tgt_core]) |=> (tb_load == '0 && xfer_err)); // R6
  AST_STOPPED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (move_wr && !tod_running) |=> (tb_load == '0 && xfer_err)); // R6
  AST_BAD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && wr_data[28] && (wr_data[43:32] != SLOT_REG)) |=> !tgt_valid); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_err && !clr_wr) |=> xfer_err); // R8
  AST_TGT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == TGT_OFS) |-> (rd_data == 64'd0)); // R7
  AST_NO_ID_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!CORE_ID_EN && tgt_wr && !wr_data[28]) |=> !tgt_valid); // R4
  AST_OTHER_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_wr && !move_wr && !clr_wr) |=> ($stable(tgt_valid) && $stable(xfer_err))); // R9
endmodule

// File: tb/sim_timebase_xfer_sel.sv
`timescale 1ns/1ps
module sim_timebase_xfer_sel;
  localparam int NC = 8;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [63:0] wr_data = 0;
  logic tod_running = 0;
  logic [NC-1:0] core_ready = 0;
  logic [63:0] rd0, rd1;
  logic [NC-1:0] ld0, ld1;
  logic v0, v1, e0, e1;
  logic [2:0] c0, c1;
  int checks = 0, errors = 0;
  logic m_valid = 0, m_err = 0;
  logic [2:0] m_idx = 0;

  always #2.5 clk = ~clk;

  timebase_xfer_sel #(.NCORES(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd0), .tod_running(tod_running), .core_ready(core_ready),
    .tb_load(ld0), .tgt_valid(v0), .tgt_core(c0), .xfer_err(e0));
  timebase_xfer_sel #(.NCORES(NC), .CORE_ID_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd1), .tod_running(tod_running), .core_ready(core_ready),
    .tb_load(ld1), .tgt_valid(v1), .tgt_core(c1), .xfer_err(e1));

  function automatic logic [31:0] base_of(int c);
    return 32'h2000_0000 + 32'h0100_0000 * c;
  endfunction
  function automatic logic [63:0] full_word(logic [31:0] a);
    return {a, 3'b0, 1'b1, 28'b0};
  endfunction
  function automatic logic [63:0] id_word(logic [5:0] id);
    return {26'b0, id, 32'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [5:0] wa, input logic [63:0] wd, input string req);
    logic nv, ne; logic [2:0] ni; logic [NC-1:0] es; logic [31:0] a; logic [4:0] id;
    wr_en = we; wr_addr = wa; wr_data = wd;
    nv = m_valid; ni = m_idx; ne = m_err; es = '0;
    if (we && wa == 6'h27) begin
      nv = 0;
      if (wd[28]) begin
        a = wd[63:32];
        if (a[11:0] == 12'h4A3)
          for (int c = 0; c < NC; c++)
            if (a[31:12] == base_of(c) >> 12) begin nv = 1; ni = 3'(c); end
      end else begin
        id = wd[36:32];
        if (id < NC) begin nv = 1; ni = id[2:0]; end
      end
    end else if (we && wa == 6'h17) begin
      if (tod_running && wd[63] && m_valid && core_ready[m_idx]) es = NC'(1) << m_idx;
      else ne = 1;
    end else if (we && wa == 6'h30 && wd[63]) ne = 0;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    m_valid = nv; m_err = ne; if (nv) m_idx = ni;
    chk(ld0 == es, {req, " strobe"}, 64'(ld0), 64'(es));
    chk(v0 == nv, {req, " valid"}, 64'(v0), 64'(nv));
    if (nv) chk(c0 == ni, {req, " core"}, 64'(c0), 64'(ni));
    chk(e0 == ne, {req, " err"}, 64'(e0), 64'(ne));
    chk(rd0 == ((rd_addr == 6'h30) ? {ne, 63'b0} : 64'd0), "R7 read", rd0,
        (rd_addr == 6'h30) ? {ne, 63'b0} : 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(v0 == 0 && e0 == 0 && ld0 == 0, "R1 reset", {ld0, v0, e0}, 64'd0);

    // directed corner cases
    tod_running = 1; core_ready = '1;
    step(1, 6'h17, 64'h8000_0000_0000_0000, "R6 no target");
    rd_addr = 6'h30; step(0, 0, 0, "R7 err read");
    step(1, 6'h30, 64'h8000_0000_0000_0000, "R8 clear");
    step(1, 6'h27, full_word(base_of(5) | 32'h4A3), "R2 full addr");
    step(1, 6'h17, 64'h8000_0000_0000_0000, "R5 move");
    step(0, 0, 0, "R5 pulse ends");
    step(1, 6'h27, full_word(base_of(5) | 32'h4A4), "R3 bad slot");
    step(1, 6'h27, full_word(32'h7000_04A3), "R3 no base");
    step(1, 6'h27, id_word(6'h23), "R4 masked id");
    chk(v1 == 0, "R4 id mode off", 64'(v1), 64'd0);
    step(1, 6'h27, id_word(6'h09), "R4 id range");
    step(1, 6'h27, id_word(6'h02), "R4 id");
    step(1, 6'h17, 64'h0, "R6 cmd bit clear");
    step(1, 6'h12, 64'hFFFF_FFFF_FFFF_FFFF, "R9 other ofs");
    step(1, 6'h30, 64'h0, "R8 no clear");
    core_ready = 8'hFB;
    step(1, 6'h17, 64'h8000_0000_0000_0000, "R6 not ready");
    core_ready = '1; tod_running = 0;
    step(1, 6'h17, 64'h8000_0000_0000_0000, "R6 not running");
    rd_addr = 6'h27; step(0, 0, 0, "R7 tgt read zero");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op; logic [63:0] d; string rq;
      tod_running = ($urandom % 5) != 0;
      core_ready = NC'($urandom) | NC'($urandom);
      case ($urandom % 3)
        0: rd_addr = 6'h27; 1: rd_addr = 6'h30; default: rd_addr = 6'($urandom);
      endcase
      op = $urandom % 8;
      case (op)
        0: begin d = full_word(base_of($urandom % NC) | 32'h4A3); rq = "R2 rnd"; end
        1: begin d = full_word(base_of($urandom % NC) | 32'($urandom % 4096)); rq = "R3 rnd"; end
        2: begin d = id_word(6'($urandom)); rq = "R4 rnd"; end
        default: d = {$urandom, $urandom};
      endcase
      if (op <= 2) step(1, 6'h27, d, rq);
      else if (op <= 4) step(1, 6'h17, {($urandom % 4) != 0, 63'($urandom)}, "R5 R6 rnd");
      else if (op == 5) step(1, 6'h30, {($urandom % 2) != 0, 63'b0}, "R8 rnd");
      else if (op == 6) step(1, 6'h08, d, "R9 rnd");
      else step(0, 0, 0, "R9 idle");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule